// File: doc/BRIEF.md
# Signal-Degrade Defect Detector

This block watches B2 parity results on a line and declares a signal-degrade defect once the error count in a monitor window meets a programmed threshold. Every frame, upstream logic gives one strobe and a vector of B2 mismatch bytes, one per B2 byte of the frame. The block reduces that vector to a weight. In per-bit mode the weight is the number of mismatched bits. In per-byte mode it is the number of B2 bytes with any mismatch. The weights are summed into a saturating tally.

The window is a number of seconds, counted on a one-second tick input. Reaching the 16-bit threshold sets the defect at once, so a short burst that spans two frames can set it by itself. At each window boundary the tally restarts. If the window that just ended stayed below the threshold, the defect is cleared. Every change of the defect state sets a sticky interrupt flag, which software clears by writing 1. An enable bit gates that flag onto the interrupt pin.

A small byte-wide register port holds the window, the two threshold bytes, the control bits and a read-only view of the tally. Writing the window or either threshold byte restarts the tally and the seconds count.

Top module: `sd_defect_detector`

## Requirements
- R1: In per-bit mode (control bit 0 = 1), a frame strobe adds the number of set bits across the whole mismatch vector to the tally.
- R2: In per-byte mode (control bit 0 = 0), a frame strobe adds the number of 8-bit lanes (lane i = bits 8i+7..8i) that have at least one set bit.
- R3: The tally saturates at 0xFFFF. It never wraps and never decreases except on a window boundary or a restart.
- R4: The defect output rises at the clock edge that samples a frame which brings the tally to or above the threshold {reg 1, reg 2}.
- R5: With window value W (0 acts as 1), the W-th second tick after a restart or boundary is a boundary, and the tally reads 0 after it. Earlier ticks leave the tally unchanged.
- R6: At a boundary, a declared defect clears if the tally of the ending window is below the threshold, and stays set otherwise.
- R7: Every change of the defect state sets the sticky flag (control bit 2). Writing the control register with bit 2 = 1 clears it.
- R8: The irq pin equals the sticky flag ANDed with the enable (control bit 1).
- R9: A write to register 0, 1 or 2 zeroes the tally and the seconds count. A frame strobe or tick in that same cycle is ignored.
- R10: Register map. 0: window seconds. 1: threshold high byte. 2: threshold low byte. 3: control, with {4'b0, defect, sticky, enable, mode}. 4: tally high byte. 5: tally low byte. Read data is combinational from reg_addr.
- R11: After reset: window 167, threshold 104, per-bit mode, interrupt disabled, tally 0, defect 0, sticky 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | One-cycle strobe: b2_err holds this frame's mismatches |
| b2_err | input | NUM_B2*8 | B2 mismatch vector, one byte per B2 byte |
| sec_tick | input | 1 | One-cycle pulse every second |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| defect | output | 1 | Signal-degrade defect state |
| irq | output | 1 | Gated change-of-defect interrupt |

## Verification
Saturation is the hardest case to reach from the ports. The tally only gets there after about 680 frames that are fully errored, with no window boundary in between. The stimulus therefore sends no ticks during that stretch and sets the threshold to its maximum so that it does not interfere. A second awkward case is a defect that is set and must survive a boundary. For that, the bench builds a window whose tally is exactly at the threshold before ticking it out, and later a window whose tally is below the threshold, so that both sides of the clear rule are seen.

// File: rtl/sd_pkg.sv
package sd_pkg;
  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [2:0] {
    A_WIN      = 3'd0,
    A_THR_HI   = 3'd1,
    A_THR_LO   = 3'd2,
    A_CTRL     = 3'd3,
    A_TALLY_HI = 3'd4,
    A_TALLY_LO = 3'd5
  } reg_addr_e;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? CNT_MAX : s[CNT_W-1:0];
  endfunction

  function automatic logic [3:0] ones8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b0, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/sd_weight.sv
module sd_weight #(
  parameter int NUM_B2 = 12,
  parameter int W_W    = $clog2(NUM_B2 * 8 + 1)
) (
  input  logic [NUM_B2*8-1:0] err,
  input  logic                per_bit,
  output logic [W_W-1:0]      weight
);
  logic [3:0]        lane_bits [NUM_B2];
  logic [NUM_B2-1:0] lane_hit;

  for (genvar g = 0; g < NUM_B2; g++) begin : g_lane
    assign lane_bits[g] = sd_pkg::ones8(err[8*g +: 8]);
    assign lane_hit[g]  = |err[8*g +: 8];
  end

  always_comb begin
    weight = '0;
    for (int i = 0; i < NUM_B2; i++) begin
      if (per_bit) weight = weight + W_W'(lane_bits[i]);
      else         weight = weight + W_W'(lane_hit[i]);
    end
  end
endmodule

// File: rtl/sd_sec_timer.sv
module sd_sec_timer #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [WIN_W-1:0] win,
  output logic             boundary
);
  logic [WIN_W-1:0] sec_cnt;
  logic [WIN_W-1:0] eff_win;

  assign eff_win  = (win == '0) ? WIN_W'(1) : win;
  assign boundary = tick && !restart &&
                    (({1'b0, sec_cnt} + 1'b1) >= {1'b0, eff_win});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sec_cnt <= '0;
    else if (restart)  sec_cnt <= '0;
    else if (boundary) sec_cnt <= '0;
    else if (tick)     sec_cnt <= sec_cnt + 1'b1;
  end

  AST_SEC_BELOW_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    sec_cnt < eff_win) else $error("seconds count past window"); // R5
endmodule

// File: rtl/sd_tally.sv
module sd_tally #(
  parameter int W_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame,
  input  logic [W_W-1:0]           weight,
  input  logic                     boundary,
  input  logic                     restart,
  input  logic [sd_pkg::CNT_W-1:0] thr,
  output logic [sd_pkg::CNT_W-1:0] tally,
  output logic                     defect,
  output logic                     change
);
  import sd_pkg::*;

  logic [CNT_W-1:0] base, sum, tally_nxt;
  logic             set_evt, clr_evt, defect_nxt;

  always_comb begin
    base       = boundary ? '0 : tally;
    sum        = sat_add(base, CNT_W'(weight));
    set_evt    = frame && !restart && (sum >= thr);
    clr_evt    = boundary && defect && (tally < thr);
    defect_nxt = set_evt | (defect & ~clr_evt);
    if (restart)       tally_nxt = '0;
    else if (frame)    tally_nxt = sum;
    else if (boundary) tally_nxt = '0;
    else               tally_nxt = tally;
  end

  assign change = defect_nxt != defect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tally  <= '0;
      defect <= 1'b0;
    end else begin
      tally  <= tally_nxt;
      defect <= defect_nxt;
    end
  end

  AST_TALLY_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !boundary) |=> tally >= $past(tally)) else $error("tally fell"); // R3
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tally == CNT_MAX && !restart && !boundary) |=> tally == CNT_MAX) else $error("tally wrapped"); // R3
  AST_DECLARE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && !restart && !boundary && tally >= thr) |=> defect) else $error("missed declare"); // R4
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !restart && !frame && tally < thr) |=> !defect) else $error("missed clear"); // R6
endmodule

// File: rtl/sd_defect_detector.sv
module sd_defect_detector #(
  parameter int NUM_B2 = 12,
  parameter int WIN_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_valid,
  input  logic [NUM_B2*8-1:0] b2_err,
  input  logic                sec_tick,
  input  logic                reg_wr,
  input  logic [2:0]          reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  output logic                defect,
  output logic                irq
);
  import sd_pkg::*;

  localparam int W_W = $clog2(NUM_B2 * 8 + 1);
  localparam logic [WIN_W-1:0] WIN_RST = WIN_W'(167);
  localparam logic [CNT_W-1:0] THR_RST = CNT_W'(104);

  logic [WIN_W-1:0] win_q;
  logic [7:0]       thr_hi_q, thr_lo_q;
  logic             mode_bit_q, irq_en_q, sticky_q;
  logic [CNT_W-1:0] tally;
  logic [W_W-1:0]   weight;
  logic             boundary, change, cfg_wr, ctrl_wr;

  assign cfg_wr  = reg_wr && (reg_addr == A_WIN || reg_addr == A_THR_HI ||
                              reg_addr == A_THR_LO);
  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q      <= WIN_RST;
      thr_hi_q   <= THR_RST[15:8];
      thr_lo_q   <= THR_RST[7:0];
      mode_bit_q <= 1'b1;
      irq_en_q   <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_WIN:    win_q    <= WIN_W'(reg_wdata);
        A_THR_HI: thr_hi_q <= reg_wdata;
        A_THR_LO: thr_lo_q <= reg_wdata;
        A_CTRL: begin
          mode_bit_q <= reg_wdata[0];
          irq_en_q   <= reg_wdata[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      sticky_q <= 1'b0;
    else if (change)                 sticky_q <= 1'b1;
    else if (ctrl_wr && reg_wdata[2]) sticky_q <= 1'b0;
  end

  sd_weight #(.NUM_B2(NUM_B2), .W_W(W_W)) u_weight (
    .err(b2_err), .per_bit(mode_bit_q), .weight(weight)
  );

  sd_sec_timer #(.WIN_W(WIN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(cfg_wr), .tick(sec_tick),
    .win(win_q), .boundary(boundary)
  );

  sd_tally #(.W_W(W_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .frame(frame_valid), .weight(weight),
    .boundary(boundary), .restart(cfg_wr), .thr({thr_hi_q, thr_lo_q}),
    .tally(tally), .defect(defect), .change(change)
  );

  assign irq = sticky_q & irq_en_q;

  always_comb begin
    case (reg_addr)
      A_WIN:      reg_rdata = 8'(win_q);
      A_THR_HI:   reg_rdata = thr_hi_q;
      A_THR_LO:   reg_rdata = thr_lo_q;
      A_CTRL:     reg_rdata = {4'b0, defect, sticky_q, irq_en_q, mode_bit_q};
      A_TALLY_HI: reg_rdata = tally[15:8];
      A_TALLY_LO: reg_rdata = tally[7:0];
      default:    reg_rdata = 8'h00;
    endcase
  end

  AST_WEIGHT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    weight <= (mode_bit_q ? W_W'(NUM_B2 * 8) : W_W'(NUM_B2))) else $error("weight range"); // R1
  AST_STICKY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    change |=> sticky_q) else $error("sticky not set"); // R7
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> tally == '0) else $error("restart kept tally"); // R9
endmodule

// File: tb/sim_sd_defect_detector.sv
module sim_sd_defect_detector;
  localparam int NB = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_valid = 1'b0;
  logic [NB*8-1:0] b2_err = '0;
  logic          sec_tick = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = 3'd0;
  logic [7:0]    reg_wdata = 8'd0;
  logic [7:0]    reg_rdata;
  logic          defect, irq;

  int n_chk = 0, n_bad = 0;
  int exp_t = 0;

  always #2 clk = ~clk;

  sd_defect_detector #(.NUM_B2(NB), .WIN_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .b2_err(b2_err),
    .sec_tick(sec_tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .defect(defect), .irq(irq)
  );

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    reg_addr = a; #1; d = int'(reg_rdata);
  endtask

  task automatic rd_tally(output int t);
    int h, l;
    rd(3'd4, h); rd(3'd5, l); t = h * 256 + l;
  endtask

  task automatic send_frame(input logic [NB*8-1:0] e);
    @(negedge clk); frame_valid = 1'b1; b2_err = e;
    @(negedge clk); frame_valid = 1'b0; b2_err = '0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  function automatic int bit_cnt(input logic [NB*8-1:0] e);
    int n = 0;
    for (int i = 0; i < NB * 8; i++) if (e[i] === 1'b1) n++;
    return n;
  endfunction

  function automatic int lane_cnt(input logic [NB*8-1:0] e);
    int n = 0;
    for (int i = 0; i < NB; i++) if (e[8*i +: 8] != 8'h00) n++;
    return n;
  endfunction

  function automatic logic [NB*8-1:0] rand_err();
    logic [NB*8-1:0] e;
    logic [31:0] m;
    e = {$urandom, $urandom, $urandom};
    m = $urandom;
    for (int i = 0; i < NB; i++) if (m[i]) e[8*i +: 8] = 8'h00;
    return e;
  endfunction

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
    $finish;
  end

  initial begin
    int v, t;
    logic [NB*8-1:0] e;
    logic [NB*8-1:0] ones;
    ones = '1;
    #9 rst_n = 1'b1;
    @(negedge clk);

    // R11 / R10 reset values
    rd(3'd0, v); check(v, 167, "R11 window");
    rd(3'd1, v); check(v, 0, "R11 thr hi");
    rd(3'd2, v); check(v, 104, "R11 thr lo");
    rd(3'd3, v); check(v, 1, "R11 ctrl");
    rd_tally(t); check(t, 0, "R11 tally");
    check(int'(defect), 0, "R11 defect");
    check(int'(irq), 0, "R11 irq");

    // R1 per-bit sweep
    wr(3'd0, 8'd200); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    rd(3'd0, v); check(v, 200, "R10 window readback");
    exp_t = 0;
    for (int k = 0; k < 24; k++) begin
      e = rand_err();
      if (k == 0) e = '0;
      if (k == 1) e = ones;
      exp_t += bit_cnt(e);
      send_frame(e);
      rd_tally(t); check(t, exp_t, "R1 per-bit tally");
    end

    // R2 per-byte sweep
    wr(3'd3, 8'h00);
    for (int k = 0; k < 24; k++) begin
      e = rand_err();
      if (k == 0) e = {{(NB*8-1){1'b0}}, 1'b1};
      exp_t += lane_cnt(e);
      send_frame(e);
      rd_tally(t); check(t, exp_t, "R2 per-byte tally");
    end

    // R4 two-frame burst declare, R7/R8 interrupt
    wr(3'd1, 8'h00); wr(3'd2, 8'd192); wr(3'd3, 8'h01);
    rd_tally(t); check(t, 0, "R9 tally after threshold write");
    send_frame(ones);
    check(int'(defect), 0, "R4 below threshold");
    send_frame(ones);
    check(int'(defect), 1, "R4 declare at threshold");
    rd(3'd3, v); check((v >> 2) & 1, 1, "R7 sticky set");
    check(int'(irq), 0, "R8 irq masked");
    wr(3'd3, 8'h03);
    check(int'(irq), 1, "R8 irq enabled");
    wr(3'd3, 8'h07);
    rd(3'd3, v); check((v >> 2) & 1, 0, "R7 w1c clears");
    check(int'(irq), 0, "R8 irq after clear");

    // R5/R6 boundary clears defect below threshold
    wr(3'd0, 8'd3);
    check(int'(defect), 1, "R9 defect held over write");
    send_frame({{(NB*8-10){1'b0}}, 10'h3FF});
    tick(); tick();
    rd_tally(t); check(t, 10, "R5 tally before boundary");
    check(int'(defect), 1, "R6 defect before boundary");
    tick();
    rd_tally(t); check(t, 0, "R5 tally after boundary");
    check(int'(defect), 0, "R6 clear below threshold");
    check(int'(irq), 1, "R7 irq on clear");
    wr(3'd3, 8'h07);

    // R6 boundary keeps defect when window met threshold
    send_frame(ones); send_frame(ones);
    check(int'(defect), 1, "R4 redeclare");
    wr(3'd3, 8'h07);
    tick(); tick(); tick();
    rd_tally(t); check(t, 0, "R5 tally reset at boundary");
    check(int'(defect), 1, "R6 kept when met");
    rd(3'd3, v); check((v >> 2) & 1, 0, "R7 no change no sticky");

    // R9 restart of seconds count
    tick(); tick();
    wr(3'd2, 8'd192);
    send_frame({{(NB*8-5){1'b0}}, 5'h1F});
    tick(); tick();
    rd_tally(t); check(t, 5, "R9 seconds restarted");
    tick();
    rd_tally(t); check(t, 0, "R9 boundary after restart");

    // R9 frame ignored in write cycle
    @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'd3;
    frame_valid = 1'b1; b2_err = ones;
    @(negedge clk); reg_wr = 1'b0; frame_valid = 1'b0; b2_err = '0;
    rd_tally(t); check(t, 0, "R9 frame ignored on write");

    // R5 window zero acts as one
    wr(3'd0, 8'd0);
    send_frame(ones);
    tick();
    rd_tally(t); check(t, 0, "R5 window zero");

    // R3 saturation
    wr(3'd0, 8'd200); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    for (int k = 0; k < 690; k++) send_frame(ones);
    rd_tally(t); check(t, 65535, "R3 saturate");
    send_frame(ones);
    rd_tally(t); check(t, 65535, "R3 hold at max");
    check(int'(defect), 1, "R4 declare at max threshold");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule